// File: doc/BRIEF.md
# Two-Port Read/Write Memory from Replicated Banks

This block is a small on-chip memory with two independent ports, A and B. Each port can write one word and read one word in every clock cycle, at any address, and no access ever stalls. The storage uses only simple banks that have one write port and one read port each. Four such banks are used, and each port owns two of them: every word a port writes goes into both of its banks.

Each port has one bank of its own and one bank of the other port available for reading. A register array keeps one bit per address that names the port that wrote that address last. When a port reads, it fetches both candidate copies and the bit, and a multiplexer passes on the newer copy.

Reads are synchronous. The read data appears one clock after the address, and it shows the memory as it was before any write made in the same cycle as the read. Reset clears every ownership bit, so after reset each address returns the copy that port A wrote. Bank contents are undefined until they are written. The ownership array costs one flop per word, so the block is meant for shallow memories.

Top module: `dual_write_ram`

## Requirements
- R1: A word written through port A at address X in cycle t appears on `a_rdata` after the edge that ends cycle t+1, when port A reads X in cycle t+1.
- R2: Writes cross between the ports. A word written through port B is returned by a later port A read of the same address, and a word written through port A is returned by a later port B read.
- R3: Both ports can write and read in every cycle with no stall. Two writes to different addresses in the same cycle are both stored, and every later read returns the newest word for its address.
- R4: When both ports write the same address in the same cycle, port A's word is stored, and both ports read it back afterwards.
- R5: Read latency is one cycle. A read in the same cycle as a write to the same address, from either port, returns the contents from before that write.
- R6: While a port's read enable (`a_re` / `b_re`) is low, that port's read data holds its previous value.
- R7: An active-low reset on `rst_n` makes every address select port A's copy. After reset, reading an address last written by port B returns the word that port A last wrote there.
- R8: The latest writer wins over time. If ports A, B and A again write one address in successive cycles, the reads that follow return each write in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_we | input | 1 | Port A write enable |
| a_re | input | 1 | Port A read enable |
| a_addr | input | ADDR_W | Port A address, used for both read and write |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, one cycle after the address |
| b_we | input | 1 | Port B write enable |
| b_re | input | 1 | Port B read enable |
| b_addr | input | ADDR_W | Port B address, used for both read and write |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, one cycle after the address |

## Verification
The bench sets both ports on one address in a single cycle. A design that gave priority to the wrong port would return port B's word there. It reads an address while the other port writes it, which shows up a design that selects the copy with an ownership bit that has already been updated, because that read would return the new word too early. A reset after mixed writes shows whether the ownership bits really return to port A, since otherwise the newer port B copy would still be selected. Long random runs with heavy address overlap check the cross-port paths and the read hold. A bank wired to the wrong port would return stale words there.

// File: rtl/dwram_pkg.sv
package dwram_pkg;

  // Identifies which port owns a copy or most recently wrote a location
  typedef enum logic {
    OWN_A = 1'b0,
    OWN_B = 1'b1
  } owner_e;

  localparam int NUM_BANKS = 4;

  // Port that writes bank idx: banks 0,1 follow port A, banks 2,3 port B
  function automatic owner_e bank_writer(input int idx);
    if (idx < 2) return OWN_A;
    return OWN_B;
  endfunction

  // Port that reads bank idx: even banks feed port A, odd banks port B
  function automatic owner_e bank_reader(input int idx);
    if ((idx % 2) == 0) return OWN_A;
    return OWN_B;
  endfunction

endpackage

// File: rtl/dwram_bank.sv
// One-write / one-read storage bank with registered read data.
module dwram_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Read sees the array before this cycle's write
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/dwram_owner.sv
// Per-address last-writer bits plus the per-port registered selects.
module dwram_owner #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_we,
  input  logic              b_re,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              a_sel,
  output logic              b_sel
);

  logic [DEPTH-1:0] own_q;
  logic [DEPTH-1:0] own_d;

  // Next state: port B marks its copy current, port A applied last so it wins
  always_comb begin
    own_d = own_q;
    if (b_we) begin
      own_d[b_addr] = dwram_pkg::OWN_B;
    end
    if (a_we) begin
      own_d[a_addr] = dwram_pkg::OWN_A;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0;
    end else begin
      own_q <= own_d;
    end
  end

  // Selects are sampled with the read address, before this cycle's writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sel <= dwram_pkg::OWN_A;
    end else if (a_re) begin
      a_sel <= own_q[a_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_sel <= dwram_pkg::OWN_A;
    end else if (b_re) begin
      b_sel <= own_q[b_addr];
    end
  end

endmodule

// File: rtl/dwram_pick.sv
// Chooses the copy written by the most recent writer.
module dwram_pick #(
  parameter int DATA_W = 16
) (
  input  logic              sel,
  input  logic [DATA_W-1:0] copy_a,
  input  logic [DATA_W-1:0] copy_b,
  output logic [DATA_W-1:0] data_out
);

  always_comb begin
    if (sel == dwram_pkg::OWN_B) begin
      data_out = copy_b;
    end else begin
      data_out = copy_a;
    end
  end

endmodule

// File: rtl/dual_write_ram.sv
module dual_write_ram
  import dwram_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic              b_re,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  logic              bk_we   [NUM_BANKS];
  logic [ADDR_W-1:0] bk_waddr[NUM_BANKS];
  logic [DATA_W-1:0] bk_wdata[NUM_BANKS];
  logic              bk_re   [NUM_BANKS];
  logic [ADDR_W-1:0] bk_raddr[NUM_BANKS];
  logic [DATA_W-1:0] bk_q    [NUM_BANKS];

  logic              a_sel;
  logic              b_sel;
  logic [DATA_W-1:0] port_q  [2];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    if (bank_writer(g) == OWN_A) begin : g_wr_a
      assign bk_we[g]    = a_we;
      assign bk_waddr[g] = a_addr;
      assign bk_wdata[g] = a_wdata;
    end else begin : g_wr_b
      assign bk_we[g]    = b_we;
      assign bk_waddr[g] = b_addr;
      assign bk_wdata[g] = b_wdata;
    end

    if (bank_reader(g) == OWN_A) begin : g_rd_a
      assign bk_re[g]    = a_re;
      assign bk_raddr[g] = a_addr;
    end else begin : g_rd_b
      assign bk_re[g]    = b_re;
      assign bk_raddr[g] = b_addr;
    end

    dwram_bank #(
      .DATA_W(DATA_W),
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W)
    ) u_bank (
      .clk    (clk),
      .wr_en  (bk_we[g]),
      .wr_addr(bk_waddr[g]),
      .wr_data(bk_wdata[g]),
      .rd_en  (bk_re[g]),
      .rd_addr(bk_raddr[g]),
      .rd_data(bk_q[g])
    );
  end

  dwram_owner #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) u_owner (
    .clk   (clk),
    .rst_n (rst_n),
    .a_we  (a_we),
    .a_re  (a_re),
    .a_addr(a_addr),
    .b_we  (b_we),
    .b_re  (b_re),
    .b_addr(b_addr),
    .a_sel (a_sel),
    .b_sel (b_sel)
  );

  // Port p reads bank p (port A's copy) and bank p+2 (port B's copy)
  for (genvar p = 0; p < 2; p++) begin : g_port
    dwram_pick #(
      .DATA_W(DATA_W)
    ) u_pick (
      .sel     ((p == 0) ? a_sel : b_sel),
      .copy_a  (bk_q[p]),
      .copy_b  (bk_q[p+2]),
      .data_out(port_q[p])
    );
  end

  assign a_rdata = port_q[0];
  assign b_rdata = port_q[1];

endmodule

// File: rtl/dual_write_ram_check.sv
module dual_write_ram_check #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_we,
  input logic              a_re,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_wdata,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_we,
  input logic              b_re,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_wdata,
  input logic [DATA_W-1:0] b_rdata
);

  // Port activity one (s1) and two (s2) cycles back, valid only after reset
  logic              v1, v2;
  logic              s1_a_re, s1_b_re;
  logic [ADDR_W-1:0] s1_a_addr, s1_b_addr;
  logic              s2_a_we, s2_b_we;
  logic [ADDR_W-1:0] s2_a_addr, s2_b_addr;
  logic [DATA_W-1:0] s2_a_wdata, s2_b_wdata;
  logic              s1_a_we, s1_b_we;
  logic [DATA_W-1:0] s1_a_wdata, s1_b_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;          v2 <= 1'b0;
      s1_a_re <= 1'b0;     s1_b_re <= 1'b0;
      s1_a_we <= 1'b0;     s1_b_we <= 1'b0;
      s1_a_addr <= '0;     s1_b_addr <= '0;
      s1_a_wdata <= '0;    s1_b_wdata <= '0;
      s2_a_we <= 1'b0;     s2_b_we <= 1'b0;
      s2_a_addr <= '0;     s2_b_addr <= '0;
      s2_a_wdata <= '0;    s2_b_wdata <= '0;
    end else begin
      v1 <= 1'b1;          v2 <= v1;
      s1_a_re <= a_re;     s1_b_re <= b_re;
      s1_a_we <= a_we;     s1_b_we <= b_we;
      s1_a_addr <= a_addr; s1_b_addr <= b_addr;
      s1_a_wdata <= a_wdata; s1_b_wdata <= b_wdata;
      s2_a_we <= s1_a_we;  s2_b_we <= s1_b_we;
      s2_a_addr <= s1_a_addr; s2_b_addr <= s1_b_addr;
      s2_a_wdata <= s1_a_wdata; s2_b_wdata <= s1_b_wdata;
    end
  end

  // R1: port A write followed by port A read of the same address
  assert_a_write_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && s2_a_we && s1_a_re && s1_a_addr == s2_a_addr) |-> (a_rdata == s2_a_wdata));

  // R2: port B write (not overridden by A) seen by next port A read
  assert_cross_b_to_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && s2_b_we && !(s2_a_we && s2_a_addr == s2_b_addr) && s1_a_re && s1_a_addr == s2_b_addr)
    |-> (a_rdata == s2_b_wdata));

  // R4: same-address collision keeps port A's word, seen through port B
  assert_collision_a_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && s2_a_we && s2_b_we && s2_a_addr == s2_b_addr && s1_b_re && s1_b_addr == s2_a_addr)
    |-> (b_rdata == s2_a_wdata));

  // R6: read data holds while the read enable is low
  assert_a_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !a_re |=> $stable(a_rdata));

  assert_b_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !b_re |=> $stable(b_rdata));

endmodule

bind dual_write_ram dual_write_ram_check #(
  .DATA_W(DATA_W),
  .DEPTH (DEPTH)
) u_check (
  .clk    (clk),
  .rst_n  (rst_n),
  .a_we   (a_we),
  .a_re   (a_re),
  .a_addr (a_addr),
  .a_wdata(a_wdata),
  .a_rdata(a_rdata),
  .b_we   (b_we),
  .b_re   (b_re),
  .b_addr (b_addr),
  .b_wdata(b_wdata),
  .b_rdata(b_rdata)
);

// File: tb/test_dual_write_ram.sv
`timescale 1ns/1ps
module test_dual_write_ram;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 32;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk;
  logic              rst_n;
  logic              a_we, a_re, b_we, b_re;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [DATA_W-1:0] a_wdata, b_wdata, a_rdata, b_rdata;

  int checks   = 0;
  int failures = 0;

  // Requirement-level model: each port's last word per address, last writer bit
  logic [DATA_W-1:0] cp_a [DEPTH];
  logic [DATA_W-1:0] cp_b [DEPTH];
  bit                kn_a [DEPTH];
  bit                kn_b [DEPTH];
  bit                last_b [DEPTH];

  logic [DATA_W-1:0] exp_a, exp_b;
  bit                exp_a_v, exp_b_v;

  dual_write_ram #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) i_dual_write_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_we   (a_we),
    .a_re   (a_re),
    .a_addr (a_addr),
    .a_wdata(a_wdata),
    .a_rdata(a_rdata),
    .b_we   (b_we),
    .b_re   (b_re),
    .b_addr (b_addr),
    .b_wdata(b_wdata),
    .b_rdata(b_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [DATA_W-1:0] model_val(input int ad);
    return last_b[ad] ? cp_b[ad] : cp_a[ad];
  endfunction

  function automatic bit model_known(input int ad);
    return last_b[ad] ? kn_b[ad] : kn_a[ad];
  endfunction

  task automatic chk(input string tag, input string port,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s port %s actual=%h expected=%h", tag, port, act, expv);
    end
  endtask

  // Drive one cycle at the falling edge, update the model, check after the next edge
  task automatic step(input bit awe, input bit are, input int aad, input logic [DATA_W-1:0] awd,
                      input bit bwe, input bit bre, input int bad, input logic [DATA_W-1:0] bwd,
                      input string tag);
    a_we = awe; a_re = are; a_addr = ADDR_W'(aad); a_wdata = awd;
    b_we = bwe; b_re = bre; b_addr = ADDR_W'(bad); b_wdata = bwd;
    if (are) begin exp_a_v = model_known(aad); exp_a = model_val(aad); end
    if (bre) begin exp_b_v = model_known(bad); exp_b = model_val(bad); end
    if (bwe) begin cp_b[bad] = bwd; kn_b[bad] = 1'b1; last_b[bad] = 1'b1; end
    if (awe) begin cp_a[aad] = awd; kn_a[aad] = 1'b1; last_b[aad] = 1'b0; end
    @(posedge clk);
    @(negedge clk);
    if (exp_a_v) chk(tag, "A", a_rdata, exp_a);
    if (exp_b_v) chk(tag, "B", b_rdata, exp_b);
  endtask

  task automatic idle_inputs();
    a_we = 0; a_re = 0; a_addr = '0; a_wdata = '0;
    b_we = 0; b_re = 0; b_addr = '0; b_wdata = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) last_b[i] = 1'b0;  // R7: all select port A copy
    exp_a_v = 0; exp_b_v = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      kn_a[i] = 0; kn_b[i] = 0; last_b[i] = 0; cp_a[i] = '0; cp_b[i] = '0;
    end
    exp_a_v = 0; exp_b_v = 0; exp_a = '0; exp_b = '0;
    @(negedge clk);
    do_reset();

    // R1: port A write then port A read
    step(1, 0, 3, 16'h1111, 0, 0, 0, 16'h0, "R1");
    // R5: A reads 3 while B writes 3 in the same cycle -> old word
    step(0, 1, 3, 16'h0, 1, 0, 3, 16'h2222, "R1/R5");
    // R2: both ports now see B's word
    step(0, 1, 3, 16'h0, 0, 1, 3, 16'h0, "R2");
    // R2: A writes, B reads it next
    step(1, 0, 12, 16'h5A5A, 0, 0, 0, 16'h0, "R2");
    step(0, 0, 0, 16'h0, 0, 1, 12, 16'h0, "R2");
    // R5: port B reads its own address while writing it
    step(0, 0, 0, 16'h0, 1, 1, 12, 16'h7777, "R5");
    step(0, 1, 12, 16'h0, 0, 1, 12, 16'h0, "R5");
    // R4: same-address collision, A wins
    step(1, 0, 7, 16'hAAAA, 1, 0, 7, 16'hBBBB, "R4");
    step(0, 1, 7, 16'h0, 0, 1, 7, 16'h0, "R4");
    // R6: enables low, other traffic, outputs must hold
    step(1, 0, 7, 16'hC0C0, 1, 0, 8, 16'hD0D0, "R6");
    step(0, 0, 8, 16'h0, 0, 0, 7, 16'h0, "R6");
    // R8: A, B, A on one address with reads following each
    step(1, 0, 20, 16'h0A01, 0, 0, 0, 16'h0, "R8");
    step(0, 1, 20, 16'h0, 1, 0, 20, 16'h0B02, "R8");
    step(1, 1, 20, 16'h0A03, 0, 1, 20, 16'h0, "R8");
    step(0, 1, 20, 16'h0, 0, 1, 20, 16'h0, "R8");
    // R7: A then B write addr 9, reset, A's copy comes back
    step(1, 0, 9, 16'h0A0A, 0, 0, 0, 16'h0, "R7");
    step(0, 0, 0, 16'h0, 1, 0, 9, 16'h0B0B, "R7");
    step(0, 1, 9, 16'h0, 0, 0, 0, 16'h0, "R7");
    do_reset();
    step(0, 1, 9, 16'h0, 0, 1, 3, 16'h0, "R7");

    // R3: random concurrent traffic with overlapping addresses
    for (int n = 0; n < 4000; n++) begin
      int aad, bad;
      aad = int'($urandom % DEPTH);
      bad = ($urandom % 4 == 0) ? aad : int'($urandom % DEPTH);
      step(bit'($urandom % 2), bit'($urandom % 4 != 0), aad, DATA_W'($urandom),
           bit'($urandom % 2), bit'($urandom % 4 != 0), bad, DATA_W'($urandom), "R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule